// File: doc/BRIEF.md
# Receive Destination-Address Filter

This block decides, for every received frame, whether the frame is kept. Upstream logic extracts the 48-bit destination address and presents it with a one-cycle strobe. The filter checks the address in parallel against three sources. The first is a small bank of exact-match entries, one of which normally holds the station address and another the broadcast address. The second is a 64-bin multicast hash table indexed by six bits of the Ethernet CRC-32 of the address. The third is a promiscuous override. The decision leaves the block a fixed two cycles after the strobe, whichever path produced it.

Configuration arrives as 16-bit register writes. Each exact-match entry has its own enable bit. While an entry is enabled its address words are locked, so software must clear the enable before it rewrites an entry. The hash table is spread over four 16-bit words. Setting every bit of the table opens the filter to all multicast traffic.

Top module: `rx_addr_filter`

## Requirements
- R1: `acc_valid` is high exactly two clock cycles after each cycle with `da_valid` high, and low otherwise; the latency is the same whether promiscuous mode, an exact entry or the hash table decides.
- R2: With control register (address 0) bit 0 set (promiscuous), every frame is accepted, unicast or multicast.
- R3: The hash index is bits 28:23 of the Ethernet CRC-32 (seed all ones, polynomial 0x04C11DB7, each byte taken least significant bit first, no final inversion) over the six address bytes in transmission order. `da[47:40]` is the first byte. Index bits 5:4 pick the hash word at address 4 + word, and index bits 3:0 pick the bit in that word. A multicast frame whose selected bit is 1 is accepted when control bit 1 (hash enable) is set.
- R4: With hash enable clear, the hash table has no effect: a multicast frame that matches no enabled entry is rejected even if its bin is set.
- R5: A frame is multicast when its first transmitted bit (`da[40]`) is 1. A unicast frame is never accepted through the hash table, even when all 64 bins are set.
- R6: With hash enable set and all four hash words at 0xFFFF, every multicast frame is accepted.
- R7: Exact entry i occupies addresses 8+4i (low), 9+4i (mid) and 10+4i (high). The low word holds byte1 in bits 15:8 and byte0 in bits 7:0, the mid word holds byte3:byte2, and the high word holds byte5:byte4. An enabled entry equal to the address accepts the frame.
- R8: Register 1 bit i enables exact entry i. A disabled entry matches nothing.
- R9: A write to an address word of an enabled entry is ignored. The entry keeps matching its old address.
- R10: An enabled entry programmed to all ones accepts broadcast frames without the hash table.
- R11: After reset all configuration is zero: `acc_valid` is low and no frame is accepted.
- R12: `accept` is low whenever `acc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first transmitted byte in bits 47:40 |
| acc_valid | output | 1 | Decision valid, two cycles after `da_valid` |
| accept | output | 1 | Frame accepted |

## Verification
The filter is tried with unicast addresses that equal or miss an exact entry by one byte, with the broadcast address, and with multicast addresses whose hash bins are set or clear. These patterns separate a fault in the byte-swapped entry layout from a fault in the CRC bit order or the bin selection. Each multicast address is replayed with hash enable on and off, and with a full table, so a hash path that ignores its gate or leaks to unicast shows up. Promiscuous traffic and back-to-back strobes with gaps check that every path has the same latency. Rewrites of a locked entry are followed by frames to both the old and the new address.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned DA_BYTES   = 6;
  localparam int unsigned DA_W       = 8 * DA_BYTES;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned HASH_IDX_W = 6;
  localparam int unsigned HASH_BITS  = 1 << HASH_IDX_W;
  localparam int unsigned HASH_WORDS = HASH_BITS / WORD_W;
  localparam int unsigned HASH_LSB   = 23;
  localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;

  // CRC-32 over the address bytes in transmission order, each byte LSB first
  function automatic logic [HASH_IDX_W-1:0] bin_of(input logic [DA_W-1:0] addr);
    logic [31:0] crc;
    logic        fb;
    crc = '1;
    for (int b = 0; b < DA_BYTES; b++) begin
      for (int k = 0; k < 8; k++) begin
        fb  = crc[31] ^ addr[DA_W - 8*(b+1) + k];
        crc = {crc[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
      end
    end
    return crc[HASH_LSB +: HASH_IDX_W];
  endfunction

  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int NUM_EXACT = 4,
  parameter int CFG_AW    = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [WORD_W-1:0]         cfg_wdata,
  output logic                      promisc,
  output logic                      hash_en,
  output logic [NUM_EXACT-1:0]      entry_en,
  output logic [HASH_BITS-1:0]      hash_tbl,
  output logic [NUM_EXACT*DA_W-1:0] entry_addr
);
  localparam int CTRL_ADDR  = 0;
  localparam int EN_ADDR    = 1;
  localparam int HASH_BASE  = 4;
  localparam int ENTRY_BASE = 8;
  localparam int ENTRY_STR  = 4;
  localparam int ENTRY_WRDS = DA_W / WORD_W;

  initial begin
    if (ENTRY_BASE + ENTRY_STR * NUM_EXACT > (1 << CFG_AW))
      $error("configuration space too small for the entry count");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      promisc  <= 1'b0;
      hash_en  <= 1'b0;
      entry_en <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(CTRL_ADDR)) begin
        promisc <= cfg_wdata[0];
        hash_en <= cfg_wdata[1];
      end
      if (cfg_addr == CFG_AW'(EN_ADDR))
        entry_en <= cfg_wdata[NUM_EXACT-1:0];
    end
  end

  logic [WORD_W-1:0] hash_q [HASH_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < HASH_WORDS; k++) hash_q[k] <= '0;
    end else if (cfg_we) begin
      for (int k = 0; k < HASH_WORDS; k++)
        if (cfg_addr == CFG_AW'(HASH_BASE + k)) hash_q[k] <= cfg_wdata;
    end
  end

  for (genvar k = 0; k < HASH_WORDS; k++) begin : g_hash
    assign hash_tbl[k*WORD_W +: WORD_W] = hash_q[k];
  end

  for (genvar i = 0; i < NUM_EXACT; i++) begin : g_entry
    logic [WORD_W-1:0] word_q [ENTRY_WRDS];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int j = 0; j < ENTRY_WRDS; j++) word_q[j] <= '0;
      end else if (cfg_we && !entry_en[i]) begin
        for (int j = 0; j < ENTRY_WRDS; j++)
          if (cfg_addr == CFG_AW'(ENTRY_BASE + ENTRY_STR*i + j)) word_q[j] <= cfg_wdata;
      end
    end

    // low word holds the first two bytes, swapped
    for (genvar j = 0; j < ENTRY_WRDS; j++) begin : g_word
      assign entry_addr[i*DA_W + DA_W - WORD_W*(j+1) +: WORD_W] = swap_bytes(word_q[j]);

      a_r9_locked_word: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && entry_en[i] && cfg_addr == CFG_AW'(ENTRY_BASE + ENTRY_STR*i + j))
        |=> $stable(word_q[j]));
    end
  end
endmodule

// File: rtl/rxf_match.sv
module rxf_match
  import rxf_pkg::*;
#(
  parameter int NUM_EXACT = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      da_valid,
  input  logic [DA_W-1:0]           da,
  input  logic                      promisc,
  input  logic                      hash_en,
  input  logic [NUM_EXACT-1:0]      entry_en,
  input  logic [NUM_EXACT*DA_W-1:0] entry_addr,
  output logic                      s1_valid,
  output logic                      s1_mcast,
  output logic                      s1_hit,
  output logic                      s1_promisc,
  output logic                      s1_hash_en,
  output logic [HASH_IDX_W-1:0]     s1_bin
);
  localparam int GROUP_BIT = DA_W - 8;

  logic [NUM_EXACT-1:0] eq_vec;

  for (genvar i = 0; i < NUM_EXACT; i++) begin : g_cmp
    assign eq_vec[i] = entry_en[i] && (entry_addr[i*DA_W +: DA_W] == da);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_mcast   <= 1'b0;
      s1_hit     <= 1'b0;
      s1_promisc <= 1'b0;
      s1_hash_en <= 1'b0;
      s1_bin     <= '0;
    end else begin
      s1_valid   <= da_valid;
      s1_mcast   <= da[GROUP_BIT];
      s1_hit     <= da_valid && (|eq_vec);
      s1_promisc <= promisc;
      s1_hash_en <= hash_en;
      s1_bin     <= bin_of(da);
    end
  end

  a_r1_stage_follow: assert property (@(posedge clk) disable iff (rst)
    da_valid |=> s1_valid);
  a_r1_stage_idle: assert property (@(posedge clk) disable iff (rst)
    !da_valid |=> !s1_valid);
  a_r8_no_enabled_entry: assert property (@(posedge clk) disable iff (rst)
    (entry_en == '0) |=> !s1_hit);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int NUM_EXACT = 4,
  parameter int CFG_AW    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              da_valid,
  input  logic [47:0]       da,
  output logic              acc_valid,
  output logic              accept
);
  logic                      promisc, hash_en;
  logic [NUM_EXACT-1:0]      entry_en;
  logic [HASH_BITS-1:0]      hash_tbl;
  logic [NUM_EXACT*DA_W-1:0] entry_addr;

  logic                  s1_valid, s1_mcast, s1_hit, s1_promisc, s1_hash_en;
  logic [HASH_IDX_W-1:0] s1_bin;

  rxf_cfg_regs #(.NUM_EXACT(NUM_EXACT), .CFG_AW(CFG_AW)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .promisc    (promisc),
    .hash_en    (hash_en),
    .entry_en   (entry_en),
    .hash_tbl   (hash_tbl),
    .entry_addr (entry_addr)
  );

  rxf_match #(.NUM_EXACT(NUM_EXACT)) u_match (
    .clk        (clk),
    .rst        (rst),
    .da_valid   (da_valid),
    .da         (da),
    .promisc    (promisc),
    .hash_en    (hash_en),
    .entry_en   (entry_en),
    .entry_addr (entry_addr),
    .s1_valid   (s1_valid),
    .s1_mcast   (s1_mcast),
    .s1_hit     (s1_hit),
    .s1_promisc (s1_promisc),
    .s1_hash_en (s1_hash_en),
    .s1_bin     (s1_bin)
  );

  // flat table: word = bin[5:4], bit = bin[3:0]
  logic bin_set;
  assign bin_set = hash_tbl[s1_bin];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      accept    <= 1'b0;
    end else begin
      acc_valid <= s1_valid;
      accept    <= s1_valid && (s1_promisc || s1_hit || (s1_mcast && s1_hash_en && bin_set));
    end
  end

  a_r1_out_follow: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> acc_valid);
  a_r12_quiet_accept: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> !accept);
  a_r2_promisc_all: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_promisc) |=> accept);
  a_r7_exact_hit: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_hit) |=> accept);
  a_r5_unicast_no_hash: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_mcast && !s1_hit && !s1_promisc) |=> !accept);
  a_r4_hash_gated: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_hash_en && !s1_hit && !s1_promisc) |=> !accept);
endmodule

// File: tb/rx_addr_filter_test.sv
`timescale 1ns/1ps
module rx_addr_filter_test;
  localparam int NE = 4;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          da_valid = 1'b0;
  logic [47:0]   da = '0;
  logic          acc_valid, accept;

  rx_addr_filter #(.NUM_EXACT(NE), .CFG_AW(AW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .da_valid(da_valid), .da(da), .acc_valid(acc_valid), .accept(accept));

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural mirror of the programmed state
  logic [15:0] ctrl_m = '0;
  logic [NE-1:0] en_m = '0;
  logic [15:0] hw_m [4];
  logic [15:0] ew_m [NE][3];

  logic  held_v = 1'b0;
  logic  held_a = 1'b0;
  string held_tag = "R11";

  function automatic int crc_bin(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  o;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      o = a[47 - 8*b -: 8];
      for (int k = 0; k < 8; k++) begin
        if (c[31] ^ o[0]) c = (c << 1) ^ 32'h04C1_1DB7;
        else              c = c << 1;
        o = o >> 1;
      end
    end
    return int'((c >> 23) & 32'h3F);
  endfunction

  function automatic logic [47:0] entry_of(input int i);
    return {ew_m[i][0][7:0], ew_m[i][0][15:8], ew_m[i][1][7:0], ew_m[i][1][15:8],
            ew_m[i][2][7:0], ew_m[i][2][15:8]};
  endfunction

  function automatic logic model(input logic [47:0] a);
    int b;
    if (ctrl_m[0]) return 1'b1;
    for (int i = 0; i < NE; i++)
      if (en_m[i] && entry_of(i) == a) return 1'b1;
    if (a[40] && ctrl_m[1]) begin
      b = crc_bin(a);
      return hw_m[b / 16][b % 16];
    end
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic got, input logic exp, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare_now();
    check(held_tag, acc_valid, held_v, "acc_valid");
    check(held_tag, accept, held_a, "accept");
  endtask

  task automatic send(input logic v, input logic [47:0] a, input string tag);
    logic e;
    e = v ? model(a) : 1'b0;
    da_valid = v; da = a; cfg_we = 1'b0;
    @(posedge clk); #1;
    compare_now();
    held_v = v; held_a = e; held_tag = v ? tag : "R12";
    da_valid = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [15:0] d);
    int i, j;
    da_valid = 1'b0; cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = d;
    @(posedge clk); #1;
    compare_now();
    held_v = 1'b0; held_a = 1'b0; held_tag = "R12";
    cfg_we = 1'b0;
    if (addr == 0) ctrl_m = d;
    else if (addr == 1) en_m = d[NE-1:0];
    else if (addr >= 4 && addr < 8) hw_m[addr-4] = d;
    else if (addr >= 8) begin
      i = (addr - 8) / 4; j = (addr - 8) % 4;
      if (i < NE && j < 3 && !en_m[i]) ew_m[i][j] = d;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) send(1'b0, '0, "R12");
  endtask

  localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] STA2  = 48'h02_AB_CD_EF_01_23;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC1   = 48'h01_00_5E_00_00_01;

  initial begin
    logic [47:0] mc2;
    int b1;
    for (int k = 0; k < 4; k++) hw_m[k] = '0;
    for (int i = 0; i < NE; i++) for (int j = 0; j < 3; j++) ew_m[i][j] = '0;

    repeat (3) @(posedge clk);
    #1;
    check("R11", acc_valid, 1'b0, "acc_valid in reset");
    check("R11", accept, 1'b0, "accept in reset");
    rst = 1'b0;
    idle(2);

    // R11: nothing accepted with cleared configuration
    send(1'b1, STA, "R11");
    send(1'b1, BCAST, "R11");
    send(1'b1, MC1, "R11");
    idle(2);

    // R7: station entry 0, byte-swapped words
    wr(8, 16'h1102); wr(9, 16'h3322); wr(10, 16'h5544);
    send(1'b1, STA, "R8");          // still disabled
    wr(1, 16'h0001);
    send(1'b1, STA, "R7");
    send(1'b1, 48'h02_11_22_33_44_54, "R7");
    send(1'b1, 48'h03_11_22_33_44_55, "R7");
    send(1'b1, STA, "R1");           // back-to-back
    send(1'b1, STA, "R1");
    idle(1);
    send(1'b1, 48'h55_44_33_22_11_02, "R7");
    idle(2);

    // R10: broadcast entry 1, hash disabled
    wr(12, 16'hFFFF); wr(13, 16'hFFFF); wr(14, 16'hFFFF);
    send(1'b1, BCAST, "R8");
    wr(1, 16'h0003);
    send(1'b1, BCAST, "R10");
    send(1'b1, MC1, "R10");
    idle(2);

    // R9: rewrite of an enabled entry is ignored
    wr(8, 16'hAAAA); wr(10, 16'h0000);
    send(1'b1, STA, "R9");
    send(1'b1, 48'h02_AA_22_33_44_55, "R9");
    // R8: disable, rewrite, enable
    wr(1, 16'h0002);
    send(1'b1, STA, "R8");
    wr(8, 16'hAB02); wr(9, 16'hEFCD); wr(10, 16'h2301);
    wr(1, 16'h0003);
    send(1'b1, STA2, "R8");
    send(1'b1, STA, "R8");
    idle(2);

    // R3: one hash bin set
    b1 = crc_bin(MC1);
    wr(4 + b1 / 16, 16'(1 << (b1 % 16)));
    send(1'b1, MC1, "R4");
    wr(0, 16'h0002);
    send(1'b1, MC1, "R3");
    mc2 = MC1;
    for (int k = 2; k < 256; k++) begin
      mc2[7:0] = 8'(k);
      if (crc_bin(mc2) != b1) break;
    end
    send(1'b1, mc2, "R3");
    send(1'b1, MC1, "R3");
    send(1'b1, 48'h00_00_5E_00_00_01, "R5");
    // R4: hash disabled again
    wr(0, 16'h0000);
    send(1'b1, MC1, "R4");
    send(1'b1, mc2, "R4");
    idle(2);

    // R6: full table
    for (int k = 0; k < 4; k++) wr(4 + k, 16'hFFFF);
    wr(0, 16'h0002);
    send(1'b1, MC1, "R6");
    send(1'b1, mc2, "R6");
    send(1'b1, 48'h33_33_00_00_00_FB, "R6");
    send(1'b1, 48'h01_80_C2_00_00_0E, "R6");
    // R5: unicast never through the table
    send(1'b1, 48'h00_1B_21_3C_4D_5E, "R5");
    send(1'b1, 48'hFE_01_02_03_04_05, "R5");
    send(1'b1, STA2, "R7");
    idle(2);

    // R2: promiscuous
    wr(0, 16'h0001);
    send(1'b1, 48'h00_1B_21_3C_4D_5E, "R2");
    send(1'b1, 48'hFE_01_02_03_04_05, "R2");
    idle(1);
    send(1'b1, MC1, "R2");
    wr(0, 16'h0000);
    send(1'b1, 48'h00_1B_21_3C_4D_5E, "R2");
    idle(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule